// File: doc/BRIEF.md
# Operand Shifter with Rotate-Through-Carry

This block conditions the second operand of a data-processing datapath. It takes a data word, a shift kind, an 8-bit shift amount and the current carry flag. It returns the shifted word and the carry that the shift produces. It is purely combinational: both outputs follow the inputs within the same cycle, and no clock or reset enters the block.

Five shift kinds are supported: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right through the carry flag. In that last kind the carry acts as a 33rd bit placed above the most significant bit. Every kind and every amount from 0 to 255 has a defined result and a defined carry-out, including amounts of exactly the word width and amounts beyond it. The carry-out is always the last bit moved out of the word. When nothing moves, the incoming carry is passed through unchanged.

Amounts are not limited to the word width, so the block can take a shift count straight from a register. The word width must be a power of two.

Top module: `shb_operand_shifter`

## Requirements
- R1: With an amount of 0 and kind code 0 (left), 1 (logical right), 2 (arithmetic right) or 3 (rotate), the result equals the data input and the carry-out equals the carry input.
- R2: Kind 0 with an amount n from 1 to 31 shifts left by n and fills the low bits with zeros. The carry-out is data bit 32-n. A shift by 2 multiplies the word by 4.
- R3: Kind 1 with an amount n from 1 to 31 shifts right by n and fills the high bits with zeros. The carry-out is data bit n-1.
- R4: Kind 2 with an amount n from 1 to 31 shifts right by n and fills the high bits with copies of data bit 31. The carry-out is data bit n-1.
- R5: Kind 3 with a nonzero amount rotates right by the amount modulo 32. At a nonzero multiple of 32 the word is unchanged. The carry-out is always result bit 31.
- R6: Kind 4 ignores the amount. Result bit 31 takes the carry input, result bits 30..0 take data bits 31..1, and the carry-out is data bit 0.
- R7: Kind 0 or kind 1 with an amount of exactly 32 gives a zero result. The carry-out is data bit 0 for kind 0 and data bit 31 for kind 1.
- R8: Kind 0 or kind 1 with an amount from 33 to 255 gives a zero result and a zero carry-out.
- R9: Kind 2 with an amount from 32 to 255 sets every result bit to data bit 31, and the carry-out equals data bit 31.
- R10: Kind codes 5, 6 and 7 pass the data word and the carry input through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Data word to shift |
| kind_i | input | 3 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate through carry |
| amt_i | input | 8 | Shift amount, 0 to 255 |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Carry produced by the shift |

## Verification
Some properties can be checked on every evaluation without knowing exact bit positions. These are zero-amount pass-through, pass-through on unused kind codes, the bit mapping of the through-carry rotate, the all-zero result above the word width, sign preservation on arithmetic shifts, and the unchanged population count of a rotation. The exact carry-out bit for each in-range amount, the boundary at exactly 32, the reduction of rotate amounts modulo 32 and the times-four scaling are shown only by the bench. It compares every vector, directed and random, against an independent bit-at-a-time model.

// File: rtl/shb_pkg.sv
package shb_pkg;
  typedef enum logic [2:0] {
    SHB_LSL = 3'd0,
    SHB_LSR = 3'd1,
    SHB_ASR = 3'd2,
    SHB_ROR = 3'd3,
    SHB_RRX = 3'd4
  } shb_kind_e;
endpackage

// File: rtl/shb_log_right.sv
// Logarithmic right shifter/rotator: one stage per amount bit.
module shb_log_right #(
  parameter int DW = 32,
  localparam int SW = $clog2(DW)
) (
  input  logic [DW-1:0] data_i,
  input  logic [SW-1:0] amt_i,
  input  logic          rotate_i,
  input  logic          fill_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] stage [SW+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [DW-1:0] moved;
    always_comb begin
      if (rotate_i) moved = {stage[k][S-1:0], stage[k][DW-1:S]};
      else          moved = {{S{fill_i}}, stage[k][DW-1:S]};
    end
    assign stage[k+1] = amt_i[k] ? moved : stage[k];
  end

  assign data_o = stage[SW];
endmodule

// File: rtl/shb_carry_pick.sv
// Selects the last bit shifted out for each kind and amount.
module shb_carry_pick
  import shb_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8,
  localparam int SW = $clog2(DW)
) (
  input  logic [DW-1:0] data_i,
  input  shb_kind_e     kind_i,
  input  logic [AW-1:0] amt_i,
  input  logic          carry_i,
  input  logic          rot_msb_i,
  output logic          carry_o
);
  logic [SW-1:0] lo;
  logic [SW-1:0] idx_right;
  logic [SW-1:0] idx_left;
  logic          amt_zero;
  logic          amt_upto_dw;

  assign lo          = amt_i[SW-1:0];
  assign idx_right   = lo - SW'(1);
  assign idx_left    = SW'(0) - lo;
  assign amt_zero    = (amt_i == '0);
  assign amt_upto_dw = ({1'b0, amt_i} <= (AW+1)'(DW));

  always_comb begin
    carry_o = carry_i;
    if (kind_i == SHB_RRX) begin
      carry_o = data_i[0];
    end else if (!amt_zero) begin
      unique case (kind_i)
        SHB_LSL: carry_o = amt_upto_dw ? data_i[idx_left] : 1'b0;
        SHB_LSR: carry_o = amt_upto_dw ? data_i[idx_right] : 1'b0;
        SHB_ASR: carry_o = amt_upto_dw ? data_i[idx_right] : data_i[DW-1];
        SHB_ROR: carry_o = rot_msb_i;
        default: carry_o = carry_i;
      endcase
    end
  end
endmodule

// File: rtl/shb_operand_shifter.sv
module shb_operand_shifter
  import shb_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8,
  localparam int SW = $clog2(DW)
) (
  input  logic [DW-1:0] opnd_i,
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] amt_i,
  input  logic          carry_i,
  output logic [DW-1:0] result_o,
  output logic          carry_o
);
  shb_kind_e     kind;
  logic [SW-1:0] lo;
  logic          in_range;
  logic [DW-1:0] right_res;
  logic [DW-1:0] rev_in;
  logic [DW-1:0] rev_res;
  logic [DW-1:0] left_res;

  assign kind     = shb_kind_e'(kind_i);
  assign lo       = amt_i[SW-1:0];
  assign in_range = ({1'b0, amt_i} < (AW+1)'(DW));

  shb_log_right #(.DW(DW)) i_right (
    .data_i   (opnd_i),
    .amt_i    (lo),
    .rotate_i (kind == SHB_ROR),
    .fill_i   ((kind == SHB_ASR) & opnd_i[DW-1]),
    .data_o   (right_res)
  );

  // Left shift reuses the right shifter on a bit-reversed word.
  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign rev_in[i]   = opnd_i[DW-1-i];
    assign left_res[i] = rev_res[DW-1-i];
  end

  shb_log_right #(.DW(DW)) i_left (
    .data_i   (rev_in),
    .amt_i    (lo),
    .rotate_i (1'b0),
    .fill_i   (1'b0),
    .data_o   (rev_res)
  );

  always_comb begin
    unique case (kind)
      SHB_LSL: result_o = in_range ? left_res : '0;
      SHB_LSR: result_o = in_range ? right_res : '0;
      SHB_ASR: result_o = in_range ? right_res : {DW{opnd_i[DW-1]}};
      SHB_ROR: result_o = right_res;
      SHB_RRX: result_o = {carry_i, opnd_i[DW-1:1]};
      default: result_o = opnd_i;
    endcase
  end

  shb_carry_pick #(.DW(DW), .AW(AW)) i_carry (
    .data_i    (opnd_i),
    .kind_i    (kind),
    .amt_i     (amt_i),
    .carry_i   (carry_i),
    .rot_msb_i (right_res[DW-1]),
    .carry_o   (carry_o)
  );
endmodule

// File: rtl/shb_checks.sv
module shb_checks #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic [DW-1:0] opnd_i,
  input logic [2:0]    kind_i,
  input logic [AW-1:0] amt_i,
  input logic          carry_i,
  input logic [DW-1:0] result_o,
  input logic          carry_o
);
  logic known;
  assign known = !$isunknown({opnd_i, kind_i, amt_i, carry_i, result_o, carry_o});

  always_comb begin
    if (known) begin
      if (amt_i == '0 && kind_i < 3'd4) begin
        assert_zero_amount_R1: assert (result_o == opnd_i && carry_o == carry_i)
          else $error("zero amount altered operand");
      end
      if (kind_i == 3'd2) begin
        assert_sign_kept_R4: assert (result_o[DW-1] == opnd_i[DW-1])
          else $error("arithmetic shift lost sign");
      end
      if (kind_i == 3'd3) begin
        assert_rotate_popcount_R5: assert ($countones(result_o) == $countones(opnd_i))
          else $error("rotate changed bit count");
      end
      if (kind_i == 3'd4) begin
        assert_through_carry_R6: assert (result_o[DW-1] == carry_i &&
                                         result_o[DW-2:0] == opnd_i[DW-1:1] &&
                                         carry_o == opnd_i[0])
          else $error("rotate through carry mismatch");
      end
      if (kind_i < 3'd2 && {1'b0, amt_i} > (AW+1)'(DW)) begin
        assert_beyond_width_R8: assert (result_o == '0 && carry_o == 1'b0)
          else $error("shift beyond width not cleared");
      end
      if (kind_i > 3'd4) begin
        assert_unused_kind_R10: assert (result_o == opnd_i && carry_o == carry_i)
          else $error("unused kind altered outputs");
      end
    end
  end
endmodule

bind shb_operand_shifter shb_checks #(.DW(DW), .AW(AW)) i_checks (
  .opnd_i   (opnd_i),
  .kind_i   (kind_i),
  .amt_i    (amt_i),
  .carry_i  (carry_i),
  .result_o (result_o),
  .carry_o  (carry_o)
);

// File: tb/test_shb_operand_shifter.sv
module test_shb_operand_shifter;
  logic        clk;
  logic        rst_n;
  logic [31:0] opnd;
  logic [2:0]  kind;
  logic [7:0]  amt;
  logic        cin;
  logic [31:0] res;
  logic        cout;
  int          n_checks;
  int          n_fail;
  bit          done;

  shb_operand_shifter i_shb_operand_shifter (
    .opnd_i   (opnd),
    .kind_i   (kind),
    .amt_i    (amt),
    .carry_i  (cin),
    .result_o (res),
    .carry_o  (cout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural model: one bit position per step.
  function automatic void model(input logic [31:0] d, input int k, input int a,
                                input logic ci, output logic [31:0] r, output logic co);
    r  = d;
    co = ci;
    case (k)
      0: for (int i = 0; i < a; i++) begin co = r[31]; r = {r[30:0], 1'b0}; end
      1: for (int i = 0; i < a; i++) begin co = r[0]; r = {1'b0, r[31:1]}; end
      2: for (int i = 0; i < a; i++) begin co = r[0]; r = {r[31], r[31:1]}; end
      3: for (int i = 0; i < a; i++) begin co = r[0]; r = {r[0], r[31:1]}; end
      4: begin co = d[0]; r = {ci, d[31:1]}; end
      default: ;
    endcase
  endfunction

  function automatic string tag(input int k, input int a);
    if (k > 4) return "R10";
    if (k == 4) return "R6";
    if (a == 0) return "R1";
    if (k == 3) return "R5";
    if (k == 2) return (a >= 32) ? "R9" : "R4";
    if (a == 32) return "R7";
    if (a > 32) return "R8";
    return (k == 0) ? "R2" : "R3";
  endfunction

  task automatic apply(input logic [31:0] d, input int k, input int a, input logic ci);
    logic [31:0] er;
    logic        ec;
    @(negedge clk);
    opnd = d; kind = 3'(k); amt = 8'(a); cin = ci;
    model(d, k, a, ci, er, ec);
    @(posedge clk);
    n_checks++;
    if (res !== er || cout !== ec) begin
      n_fail++;
      $display("FAIL %s kind=%0d amt=%0d data=%h cin=%b: got %h/%b expected %h/%b",
               tag(k, a), k, a, d, ci, res, cout, er, ec);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    opnd = '0; kind = '0; amt = '0; cin = 1'b0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // R1: zero amount passes value and carry
    for (int k = 0; k < 4; k++) begin
      apply(32'hA5C3_0F81, k, 0, 1'b1);
      apply(32'h7000_0002, k, 0, 1'b0);
    end
    // R2: scale by four
    apply(32'h0000_0005, 0, 2, 1'b0);
    n_checks++;
    if (res !== 32'h0000_0014) begin
      n_fail++;
      $display("FAIL R2 times four: got %h expected %h", res, 32'h14);
    end
    apply(32'hC000_0001, 0, 1, 1'b0);
    apply(32'h8000_0000, 0, 31, 1'b0);
    // R3 / R4: right shifts, both signs
    apply(32'h8000_0001, 1, 1, 1'b0);
    apply(32'hF0F0_F0F0, 1, 31, 1'b1);
    apply(32'h8000_0010, 2, 5, 1'b0);
    apply(32'h4000_0010, 2, 31, 1'b1);
    // R7: exactly 32
    apply(32'h8000_0001, 0, 32, 1'b0);
    apply(32'h7FFF_FFFE, 0, 32, 1'b1);
    apply(32'h8000_0001, 1, 32, 1'b0);
    apply(32'h7FFF_FFFE, 1, 32, 1'b1);
    // R8: beyond 32
    apply(32'hFFFF_FFFF, 0, 33, 1'b1);
    apply(32'hFFFF_FFFF, 1, 255, 1'b1);
    // R9: arithmetic beyond width
    apply(32'h8000_0000, 2, 32, 1'b0);
    apply(32'h7FFF_FFFF, 2, 200, 1'b1);
    // R5: rotate modulo 32
    apply(32'h1234_5678, 3, 4, 1'b0);
    apply(32'h1234_5678, 3, 36, 1'b0);
    apply(32'h8000_0000, 3, 32, 1'b0);
    apply(32'h7FFF_FFFF, 3, 64, 1'b1);
    // R6: amount ignored
    apply(32'h0000_0001, 4, 0, 1'b1);
    apply(32'h0000_0002, 4, 77, 1'b0);
    // R10: unused codes
    for (int k = 5; k < 8; k++) apply(32'hDEAD_BEEF, k, 9, 1'b1);

    for (int n = 0; n < 3000; n++) begin
      int a;
      a = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 40);
      apply($urandom, int'($urandom % 8), a, 1'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule